// File: doc/BRIEF.md
# Chained Transfer Bus Sequencer

This block is the bus-master sequencer of a data transfer controller. An activation pulse makes it ask an external arbiter for the bus. Once the grant arrives, it runs a fixed sequence of bus phases, each with its own fixed length in cycles: a vector fetch, an idle slot, a descriptor read, one data move and a descriptor write-back. When the descriptor it has just read carries a chain flag, it repeats the read, move and write-back phases for the next descriptor. A single activation therefore performs as many transfers as there are chained descriptors, plus one.

A two-bit release mode sets the phase boundaries at which the bus goes back to the arbiter. The bus never goes back in the middle of a phase. After each release the sequencer drops its request for one cycle, asks again, and waits for a fresh grant before it starts the next phase. The mode register can be written only while the block is idle. A write while busy is dropped and sets a sticky error flag.

A one-cycle done pulse follows the last write-back. A cycle counter holds the number of busy cycles of the last activation, so that it can be compared with the sum of phase lengths, grant waits and release gaps. The bus interface is a plain request/grant pair. Each phase is shown on `op_valid`/`op_phase`, and the bus is owned for the whole time `op_valid` is high, so there is no back-pressure during a phase.

Top module: `ctc_bus_seq`

## Requirements
- R1: An accepted `act_req` raises `bus_req` in the next cycle. `op_valid` never rises unless `bus_gnt` was high in the cycle before.
- R2: The phases of one activation come in the order vector (code 0), idle (1), descriptor read (2), move (3), write-back (4). After a write-back the next phase is a descriptor read when the chain flag of the last descriptor was set.
- R3: Each phase keeps `op_valid` high with a stable `op_phase` for exactly its length: vector `LAT_VEC`, idle `LAT_NOP`, read `LAT_DRD`, move `LAT_MOV`, write-back `LAT_DWB`.
- R4: `bus_req` stays high throughout every phase. A release holds `bus_req` low for exactly one cycle, after which the block requests the bus again.
- R5: The release mode sets the releases per activation with N transfers: mode 00 releases at every boundary between phases (3N+1 releases); mode 01 keeps the bus from the vector fetch through the first write-back (3N-3 releases); mode 10 keeps it for the whole activation (0 releases); mode 11 behaves as 00.
- R6: A `cfg_we` pulse while `busy` is high leaves `rel_mode` unchanged. While idle, `cfg_we` loads `cfg_mode` into `rel_mode` on the next edge.
- R7: `err_cfg` is set by a configuration write while busy. Later writes do not clear it; only reset clears it.
- R8: `desc_chain` is sampled in the last cycle of each descriptor read. The number of transfers is the number of sampled set flags plus one. `xfer_cnt` counts completed moves.
- R9: `done` is high for exactly one cycle, right after the last write-back. `cyc_cnt` then equals the number of cycles with `busy` high.
- R10: `act_req` while busy is ignored. The activation ends with a single `done` and `busy` falls.
- R11: After reset `bus_req`, `op_valid`, `busy`, `done` and `err_cfg` are 0 and `rel_mode` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request, taken when idle |
| cfg_we | input | 1 | Release mode write strobe |
| cfg_mode | input | 2 | Release mode to write |
| rel_mode | output | 2 | Stored release mode |
| err_cfg | output | 1 | Sticky flag: write attempted while busy |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| op_valid | output | 1 | A bus phase is executing |
| op_phase | output | 3 | Code of the executing phase |
| desc_chain | input | 1 | Chain flag of descriptor being read |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle end-of-activation pulse |
| cyc_cnt | output | CYC_W | Busy cycles of the current or last activation |
| xfer_cnt | output | XFER_W | Moves completed in this activation |

## Verification
A wrong phase counter appears within one phase, as a run of `op_valid` that is too short or too long for its phase code. A wrong next-phase or chain decision appears at the very next phase start, as an unexpected `op_phase`. A wrong hold decision shows up at the boundary where it happens, as an extra or missing one-cycle drop of `bus_req`. Any of these errors also changes `cyc_cnt` and `xfer_cnt` when `done` arrives. The bench compares those against a closed-form sum for every combination of mode, grant delay and chain length.

// File: rtl/ctc_seq_pkg.sv
package ctc_seq_pkg;
  typedef enum logic [2:0] {
    PH_VEC = 3'd0,
    PH_NOP = 3'd1,
    PH_DRD = 3'd2,
    PH_MOV = 3'd3,
    PH_DWB = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    REL_EACH  = 2'b00,
    REL_FIRST = 2'b01,
    REL_ALL   = 2'b10,
    REL_BAD   = 2'b11
  } relmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RUN,
    ST_REL
  } state_e;
endpackage

// File: rtl/ctc_cfg_reg.sv
module ctc_cfg_reg
  import ctc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       busy,
  output logic [1:0] mode_raw,
  output relmode_e   mode_eff,
  output logic       err
);
  logic [1:0] mode_q;
  logic       err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      err_q  <= 1'b0;
    end else if (cfg_we) begin
      if (busy) err_q  <= 1'b1;
      else      mode_q <= cfg_mode;
    end
  end

  // the reserved code falls back to release-at-every-boundary
  always_comb begin
    case (mode_q)
      2'b01:   mode_eff = REL_FIRST;
      2'b10:   mode_eff = REL_ALL;
      default: mode_eff = REL_EACH;
    endcase
  end

  assign mode_raw = mode_q;
  assign err      = err_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> err_q); // R7
endmodule

// File: rtl/ctc_phase_timer.sv
module ctc_phase_timer
  import ctc_seq_pkg::*;
#(
  parameter int LAT_VEC = 2,
  parameter int LAT_NOP = 1,
  parameter int LAT_DRD = 3,
  parameter int LAT_MOV = 2,
  parameter int LAT_DWB = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  phase_e phase,
  output logic   last
);
  localparam int MAX_A = (LAT_VEC > LAT_NOP) ? LAT_VEC : LAT_NOP;
  localparam int MAX_B = (LAT_DRD > LAT_MOV) ? LAT_DRD : LAT_MOV;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L = (MAX_C > LAT_DWB) ? MAX_C : LAT_DWB;
  localparam int CNT_W = (MAX_L < 2) ? 1 : $clog2(MAX_L);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] end_val;

  always_comb begin
    case (phase)
      PH_VEC:  end_val = CNT_W'(LAT_VEC - 1);
      PH_NOP:  end_val = CNT_W'(LAT_NOP - 1);
      PH_DRD:  end_val = CNT_W'(LAT_DRD - 1);
      PH_MOV:  end_val = CNT_W'(LAT_MOV - 1);
      default: end_val = CNT_W'(LAT_DWB - 1);
    endcase
  end

  assign last = run && (cnt_q == end_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (run && !last) cnt_q <= cnt_q + 1'b1;
    else                   cnt_q <= '0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= end_val)); // R3
endmodule

// File: rtl/ctc_seq_fsm.sv
module ctc_seq_fsm
  import ctc_seq_pkg::*;
#(
  parameter int CYC_W  = 16,
  parameter int XFER_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              bus_gnt,
  input  logic              desc_chain,
  input  logic              ph_last,
  input  relmode_e          mode,
  output logic              bus_req,
  output logic              op_valid,
  output phase_e            phase,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cyc_cnt,
  output logic [XFER_W-1:0] xfer_cnt
);
  state_e            state_q;
  phase_e            phase_q;
  phase_e            phase_nxt;
  logic              chain_q;
  logic              done_q;
  logic              hold;
  logic [CYC_W-1:0]  cyc_q;
  logic [XFER_W-1:0] xfer_q;

  always_comb begin
    case (phase_q)
      PH_VEC:  phase_nxt = PH_NOP;
      PH_NOP:  phase_nxt = PH_DRD;
      PH_DRD:  phase_nxt = PH_MOV;
      PH_MOV:  phase_nxt = PH_DWB;
      default: phase_nxt = PH_DRD;
    endcase
  end

  // keep the bus across this boundary?
  assign hold = (mode == REL_ALL) || ((mode == REL_FIRST) && (xfer_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_VEC;
      chain_q <= 1'b0;
      done_q  <= 1'b0;
      cyc_q   <= '0;
      xfer_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE) cyc_q <= cyc_q + 1'b1;
      case (state_q)
        ST_IDLE: if (act_req) begin
          state_q <= ST_REQ;
          phase_q <= PH_VEC;
          chain_q <= 1'b0;
          cyc_q   <= '0;
          xfer_q  <= '0;
        end
        ST_REQ: if (bus_gnt) state_q <= ST_RUN;
        ST_REL: state_q <= ST_REQ;
        ST_RUN: if (ph_last) begin
          if (phase_q == PH_DRD) chain_q <= desc_chain;
          if (phase_q == PH_MOV) xfer_q  <= xfer_q + 1'b1;
          if ((phase_q == PH_DWB) && !chain_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= phase_nxt;
            if (!hold) state_q <= ST_REL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req  = (state_q == ST_REQ) || (state_q == ST_RUN);
  assign op_valid = (state_q == ST_RUN);
  assign phase    = phase_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign cyc_cnt  = cyc_q;
  assign xfer_cnt = xfer_q;

  AST_REQ_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && act_req) |=> bus_req); // R1
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(bus_gnt)); // R1
  AST_NO_MID_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ph_last) |=> (op_valid && bus_req && $stable(phase_q))); // R4
  AST_ORDER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ph_last && phase_q == PH_VEC) |=> (phase_q == PH_NOP)); // R2
  AST_ORDER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ph_last && phase_q == PH_NOP) |=> (phase_q == PH_DRD)); // R2
  AST_ORDER_DRD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ph_last && phase_q == PH_DRD) |=> (phase_q == PH_MOV)); // R2
  AST_ORDER_MOV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ph_last && phase_q == PH_MOV) |=> (phase_q == PH_DWB)); // R2
  AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == REL_ALL) |-> (state_q != ST_REL)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/ctc_bus_seq.sv
module ctc_bus_seq
  import ctc_seq_pkg::*;
#(
  parameter int LAT_VEC = 2,
  parameter int LAT_NOP = 1,
  parameter int LAT_DRD = 3,
  parameter int LAT_MOV = 2,
  parameter int LAT_DWB = 2,
  parameter int CYC_W   = 16,
  parameter int XFER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  output logic [1:0]        rel_mode,
  output logic              err_cfg,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              op_valid,
  output logic [2:0]        op_phase,
  input  logic              desc_chain,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cyc_cnt,
  output logic [XFER_W-1:0] xfer_cnt
);
  relmode_e mode_eff;
  phase_e   phase;
  logic     ph_last;

  ctc_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .busy     (busy),
    .mode_raw (rel_mode),
    .mode_eff (mode_eff),
    .err      (err_cfg)
  );

  ctc_phase_timer #(
    .LAT_VEC (LAT_VEC),
    .LAT_NOP (LAT_NOP),
    .LAT_DRD (LAT_DRD),
    .LAT_MOV (LAT_MOV),
    .LAT_DWB (LAT_DWB)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (op_valid),
    .phase (phase),
    .last  (ph_last)
  );

  ctc_seq_fsm #(
    .CYC_W  (CYC_W),
    .XFER_W (XFER_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_req    (act_req),
    .bus_gnt    (bus_gnt),
    .desc_chain (desc_chain),
    .ph_last    (ph_last),
    .mode       (mode_eff),
    .bus_req    (bus_req),
    .op_valid   (op_valid),
    .phase      (phase),
    .busy       (busy),
    .done       (done),
    .cyc_cnt    (cyc_cnt),
    .xfer_cnt   (xfer_cnt)
  );

  assign op_phase = phase;
endmodule

// File: tb/sim_ctc_bus_seq.sv
`timescale 1ns/1ps
module sim_ctc_bus_seq;
  localparam int LV = 2, LN = 1, LR = 3, LM = 2, LW = 2;
  localparam int CW = 16, XW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_req = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic [1:0]    rel_mode;
  logic          err_cfg, bus_req, bus_gnt, op_valid, desc_chain, busy, done;
  logic [2:0]    op_phase;
  logic [CW-1:0] cyc_cnt;
  logic [XW-1:0] xfer_cnt;

  int checks = 0;
  int fails  = 0;
  int nchain = 1;
  int gdelay = 0;
  int cycles = 0;
  logic [3:0] arb_age = '0;

  always #2.5 clk = ~clk;

  ctc_bus_seq #(.LAT_VEC(LV), .LAT_NOP(LN), .LAT_DRD(LR), .LAT_MOV(LM),
                .LAT_DWB(LW), .CYC_W(CW), .XFER_W(XW)) u0 (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .rel_mode(rel_mode), .err_cfg(err_cfg),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .op_valid(op_valid),
    .op_phase(op_phase), .desc_chain(desc_chain), .busy(busy), .done(done),
    .cyc_cnt(cyc_cnt), .xfer_cnt(xfer_cnt));

  // arbiter model: grant after gdelay cycles of continuous request
  always @(posedge clk) arb_age <= bus_req ? ((arb_age == 4'hf) ? arb_age : arb_age + 1'b1) : 4'h0;
  assign bus_gnt    = bus_req && (int'(arb_age) >= gdelay);
  assign desc_chain = (int'(xfer_cnt) < nchain - 1);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat_of(input int ph);
    case (ph)
      0: return LV;
      1: return LN;
      2: return LR;
      3: return LM;
      default: return LW;
    endcase
  endfunction

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary_and_end();
    end
  end

  task automatic write_cfg(input logic [1:0] m);
    @(negedge clk);
    cfg_mode = m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one activation; poke=1 injects a busy config write and a busy act_req
  task automatic run_one(input int mode, input int d, input int n, input bit poke);
    int rels = 0, starts = 0, runlen = 0, lowlen = 0, exp_ph = 0, wb_seen = 0;
    int exp_rel, exp_cyc, busy_cyc = 0, done_cnt = 0;
    bit prev_ov = 0, prev_req = 0, prev_gnt = 0, finished = 0;
    int prev_ph = 0;
    nchain = n; gdelay = d;
    @(negedge clk);
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
    chk(bus_req == 1'b1, "R1 req after act", int'(bus_req), 1);
    for (int t = 0; t < 1000 && !finished; t++) begin
      if (t > 0) @(negedge clk);
      if (poke) begin
        cfg_we  = (t == 3);
        cfg_mode = 2'b00;
        act_req = (t == 5);
      end
      if (busy) busy_cyc++;
      if (op_valid && (!prev_ov || int'(op_phase) != prev_ph)) begin
        chk(int'(op_phase) == exp_ph, "R2 phase order", int'(op_phase), exp_ph);
        if (!prev_ov) chk(prev_gnt, "R1 grant before phase", int'(prev_gnt), 1);
        if (prev_ov) chk(runlen == lat_of(prev_ph), "R3 phase length", runlen, lat_of(prev_ph));
        starts++;
        runlen = 1;
        if (int'(op_phase) == 4) begin
          wb_seen++;
          exp_ph = 2;
        end else exp_ph = int'(op_phase) + 1;
      end else if (op_valid) runlen++;
      if (!op_valid && prev_ov)
        chk(runlen == lat_of(prev_ph), "R3 phase length", runlen, lat_of(prev_ph));
      if (busy && prev_req && !bus_req) rels++;
      if (busy && !bus_req) lowlen++;
      if (bus_req && !prev_req && lowlen > 0) begin
        chk(lowlen == 1, "R4 release gap", lowlen, 1);
        lowlen = 0;
      end
      if (done) begin
        done_cnt++;
        finished = 1;
      end
      prev_ov = op_valid; prev_ph = int'(op_phase);
      prev_req = bus_req; prev_gnt = bus_gnt;
    end
    act_req = 1'b0; cfg_we = 1'b0;
    chk(finished, "R9 done seen", int'(finished), 1);
    exp_rel = (mode == 2) ? 0 : (mode == 1) ? 3*n - 3 : 3*n + 1;
    exp_cyc = (d + 1) + LV + LN + n*(LR + LM + LW) + exp_rel*(d + 2);
    chk(rels == exp_rel, "R5 release count", rels, exp_rel);
    chk(starts == 2 + 3*n, "R2 phase count", starts, 2 + 3*n);
    chk(wb_seen == n, "R8 write-backs", wb_seen, n);
    chk(int'(xfer_cnt) == n, "R8 transfers", int'(xfer_cnt), n);
    chk(int'(cyc_cnt) == exp_cyc, "R9 cycle total", int'(cyc_cnt), exp_cyc);
    chk(int'(cyc_cnt) == busy_cyc, "R9 cycles vs busy", int'(cyc_cnt), busy_cyc);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R10 idle after done", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b0 && bus_req == 1'b0, "R10 no extra activation", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0 && op_valid == 1'b0, "R11 reset bus", int'(bus_req), 0);
    chk(busy == 1'b0 && done == 1'b0, "R11 reset busy", int'(busy), 0);
    chk(err_cfg == 1'b0, "R11 reset err", int'(err_cfg), 0);
    chk(rel_mode == 2'b00, "R11 reset mode", int'(rel_mode), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      write_cfg(2'(m));
      chk(int'(rel_mode) == m, "R6 idle write", int'(rel_mode), m);
      for (int d = 0; d < 3; d++)
        for (int n = 1; n < 4; n++)
          run_one(m, d, n, 1'b0);
    end
    chk(err_cfg == 1'b0, "R7 no error from idle writes", int'(err_cfg), 0);
    // busy write and busy activation
    write_cfg(2'b10);
    run_one(2, 1, 2, 1'b1);
    chk(rel_mode == 2'b10, "R6 busy write ignored", int'(rel_mode), 2);
    chk(err_cfg == 1'b1, "R7 error set", int'(err_cfg), 1);
    write_cfg(2'b01);
    chk(rel_mode == 2'b01, "R6 idle write after error", int'(rel_mode), 1);
    chk(err_cfg == 1'b1, "R7 error sticky", int'(err_cfg), 1);
    run_one(1, 0, 3, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err_cfg == 1'b0, "R7 cleared by reset", int'(err_cfg), 0);
    chk(rel_mode == 2'b00, "R11 mode after reset", int'(rel_mode), 0);
    rst_n = 1'b1;
    @(negedge clk);
    summary_and_end();
  end
endmodule